// File: doc/BRIEF.md
# Trace Coprocessor Register Port

This block sits on the trace-unit side of a reduced coprocessor register interface driven by a processor core. Each transfer is split in time: the core presents a direction flag and a 15-bit register number in the cycle it raises enable, and two cycles later it presents a commit flag together with the 32-bit write value. Only a committed write reaches storage. A transfer whose commit flag is low in that later cycle is dropped with no trace left behind.

The register number is split into coprocessor fields. One address group selects among sixteen trace configuration registers, and a single fixed address on the other coprocessor selects a context identifier register. The core does not check whether a register exists, so every write that decodes to nothing is discarded silently. The read path returns zero. A two-bit security input, taken in the commit cycle, blocks writes from the non-secure state while trace is prohibited. The stored registers are presented as parallel outputs for the trace logic that uses them.

Top module: `trc_cp_port`

## Requirements
- R1: After reset all sixteen trace registers and the context register read zero.
- R2: A write whose enable is high in cycle t, with commit high in cycle t+2, stores the write data sampled in cycle t+2; the new value appears on the outputs from cycle t+3 and not earlier.
- R3: When commit is low in cycle t+2, the transfer changes no register.
- R4: The enable of a new transfer may fall in the commit cycle of the previous one, or in any cycle at all; each transfer is applied independently with its own address, direction, commit and data.
- R5: The address fields are opcode1 in bits 14:12, CRn in 11:8, CRm in 7:4, coprocessor select in bit 3 (0 trace coprocessor, 1 system coprocessor) and opcode2 in 2:0; trace register k is written when select is 0, opcode1 is 1, CRn is 0, CRm is k and opcode2 is 0.
- R6: The context register is written when select is 1, opcode1 is 0, CRn is 13, CRm is 0 and opcode2 is 1.
- R7: A write to any other address is discarded and changes no register.
- R8: A transfer with the direction flag low (read) changes no register, and the read data output is always zero.
- R9: The security input is sampled in the commit cycle; bit 1 means trace prohibited and bit 0 means non-secure. A write with both bits set is discarded; with either bit alone it proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cp_en_i | input | 1 | Transfer start; qualifies direction and address |
| cp_wr_i | input | 1 | Direction, 1 for write |
| cp_addr_i | input | 15 | Register number |
| cp_commit_i | input | 1 | Commit, two cycles after enable |
| cp_wdata_i | input | 32 | Write value, valid with commit |
| sec_ctl_i | input | 2 | Bit 1 trace prohibited, bit 0 non-secure |
| cp_rdata_o | output | 32 | Read data, always zero |
| trc_regs_o | output | 512 | Trace registers, register k in bits 32k+31:32k |
| ctx_id_o | output | 32 | Context identifier register |

## Verification
Address and direction are taken in the enable cycle, commit, data and security two edges later, and a register update shows on the outputs one edge after the commit cycle, three edges after enable. The bench keeps two pending transfers in a shadow of its own, drives each commit exactly two steps after its enable, updates a reference model only after the commit edge, and compares every output on the falling edge of each cycle, so an update that lands one cycle early or late mismatches. The read output is compared at every one of these samples.

// File: rtl/trc_cp_pkg.sv
package trc_cp_pkg;

  typedef struct packed {
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic       cp_sel;
    logic [2:0] op2;
  } cp_addr_t;

  localparam logic [2:0] TRC_OP1 = 3'd1;
  localparam logic [3:0] TRC_CRN = 4'd0;
  localparam logic [2:0] TRC_OP2 = 3'd0;

  localparam logic [2:0] CTX_OP1 = 3'd0;
  localparam logic [3:0] CTX_CRN = 4'd13;
  localparam logic [3:0] CTX_CRM = 4'd0;
  localparam logic [2:0] CTX_OP2 = 3'd1;

  localparam int SEC_NS_BIT   = 0;
  localparam int SEC_PROH_BIT = 1;

endpackage

// File: rtl/trc_cp_decode.sv
module trc_cp_decode
  import trc_cp_pkg::*;
#(
  parameter int NREG  = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  cp_addr_t         addr_i,
  input  logic             wr_i,
  output logic             hit_trc_o,
  output logic             hit_ctx_o,
  output logic [IDX_W-1:0] idx_o
);

  logic in_range;

  assign in_range  = 32'(addr_i.crm) < NREG;
  assign idx_o     = addr_i.crm[IDX_W-1:0];

  assign hit_trc_o = !addr_i.cp_sel && addr_i.op1 == TRC_OP1 &&
                     addr_i.crn == TRC_CRN && addr_i.op2 == TRC_OP2 && in_range;

  // system coprocessor side exposes one write-only register
  assign hit_ctx_o = wr_i && addr_i.cp_sel && addr_i.op1 == CTX_OP1 &&
                     addr_i.crn == CTX_CRN && addr_i.crm == CTX_CRM &&
                     addr_i.op2 == CTX_OP2;

endmodule

// File: rtl/trc_cp_pipe.sv
module trc_cp_pipe #(
  parameter int DEPTH = 2,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);

  logic         vld_q [DEPTH];
  logic [W-1:0] dat_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    logic         vld_d;
    logic [W-1:0] dat_d;
    if (k == 0) begin : g_head
      assign vld_d = vld_i;
      assign dat_d = dat_i;
    end else begin : g_body
      assign vld_d = vld_q[k-1];
      assign dat_d = dat_q[k-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[k] <= 1'b0;
        dat_q[k] <= '0;
      end else begin
        vld_q[k] <= vld_d;
        dat_q[k] <= dat_d;
      end
    end
  end

  assign vld_o = vld_q[DEPTH-1];
  assign dat_o = dat_q[DEPTH-1];

  // stage output lines up with the commit cycle of its own enable
  assert_stage_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(vld_i, DEPTH));

  assert_stage_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_q[0]);

endmodule

// File: rtl/trc_cp_regbank.sv
module trc_cp_regbank #(
  parameter int NREG  = 16,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_trc_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               wr_ctx_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [NREG*DW-1:0] regs_o,
  output logic [DW-1:0]      ctx_o
);

  logic [NREG-1:0] we_vec;
  logic [DW-1:0]   regs_q [NREG];
  logic [DW-1:0]   ctx_q;

  always_comb begin
    for (int k = 0; k < NREG; k++) begin
      we_vec[k] = wr_trc_i && (32'(idx_i) == k);
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        regs_q[k] <= '0;
      else if (we_vec[k]) regs_q[k] <= wdata_i;
    end
    assign regs_o[k*DW +: DW] = regs_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctx_q <= '0;
    else if (wr_ctx_i) ctx_q <= wdata_i;
  end

  assign ctx_o = ctx_q;

  assert_one_target_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_trc_i && wr_ctx_i));

  assert_onehot_we_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_vec));

endmodule

// File: rtl/trc_cp_port.sv
module trc_cp_port
  import trc_cp_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int DW    = 32,
  parameter int AW    = 15,
  localparam int IDX_W  = $clog2(NREG),
  localparam int LAT    = 2,
  localparam int PLD_W  = 3 + IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cp_en_i,
  input  logic               cp_wr_i,
  input  logic [AW-1:0]      cp_addr_i,
  input  logic               cp_commit_i,
  input  logic [DW-1:0]      cp_wdata_i,
  input  logic [1:0]         sec_ctl_i,
  output logic [DW-1:0]      cp_rdata_o,
  output logic [NREG*DW-1:0] trc_regs_o,
  output logic [DW-1:0]      ctx_id_o
);

  logic             d_hit_trc, d_hit_ctx;
  logic [IDX_W-1:0] d_idx;
  logic [PLD_W-1:0] pld_in, pld_out;
  logic             p_vld, p_wr, p_hit_trc, p_hit_ctx;
  logic [IDX_W-1:0] p_idx;
  logic             sec_block, go;

  trc_cp_decode #(.NREG(NREG)) i_decode (
    .addr_i    (cp_addr_t'(cp_addr_i)),
    .wr_i      (cp_wr_i),
    .hit_trc_o (d_hit_trc),
    .hit_ctx_o (d_hit_ctx),
    .idx_o     (d_idx)
  );

  assign pld_in = {cp_wr_i, d_hit_trc, d_hit_ctx, d_idx};

  // holds request phase until the commit cycle
  trc_cp_pipe #(.DEPTH(LAT), .W(PLD_W)) i_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (cp_en_i),
    .dat_i  (pld_in),
    .vld_o  (p_vld),
    .dat_o  (pld_out)
  );

  assign {p_wr, p_hit_trc, p_hit_ctx, p_idx} = pld_out;

  assign sec_block = sec_ctl_i[SEC_PROH_BIT] && sec_ctl_i[SEC_NS_BIT];
  assign go        = p_vld && p_wr && cp_commit_i && !sec_block;

  trc_cp_regbank #(.NREG(NREG), .DW(DW)) i_regbank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_trc_i (go && p_hit_trc),
    .idx_i    (p_idx),
    .wr_ctx_i (go && p_hit_ctx),
    .wdata_i  (cp_wdata_i),
    .regs_o   (trc_regs_o),
    .ctx_o    (ctx_id_o)
  );

  assign cp_rdata_o = '0;

  assert_cancel_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cp_commit_i |=> $stable(trc_regs_o) && $stable(ctx_id_o));

  assert_change_needs_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(trc_regs_o) |-> $past(cp_en_i, LAT + 1));

  assert_read_no_effect_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_vld && !p_wr) |=> $stable(trc_regs_o) && $stable(ctx_id_o));

  assert_prohibit_ns_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_commit_i && sec_ctl_i == 2'b11) |=> $stable(trc_regs_o) && $stable(ctx_id_o));

  assert_ctx_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctx_id_o) |-> $past(cp_commit_i) && $past(p_vld));

endmodule

// File: tb/test_trc_cp_port.sv
`timescale 1ns/1ps
module test_trc_cp_port;
  localparam int NREG = 16;
  localparam int DW   = 32;

  typedef struct packed {
    logic        v;
    logic        wr;
    logic        cm;
    logic [14:0] a;
    logic [31:0] d;
    logic [1:0]  s;
  } txn_t;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cp_en_i = 1'b0, cp_wr_i = 1'b0, cp_commit_i = 1'b0;
  logic [14:0]       cp_addr_i = '0;
  logic [31:0]       cp_wdata_i = '0;
  logic [1:0]        sec_ctl_i = '0;
  logic [31:0]       cp_rdata_o;
  logic [NREG*DW-1:0] trc_regs_o;
  logic [31:0]       ctx_id_o;

  logic [31:0] m_regs [NREG];
  logic [31:0] m_ctx;
  txn_t        sl1, sl2;
  int          n_chk = 0, n_fail = 0;
  string       cur_req = "R1";
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  trc_cp_port i_trc_cp_port (
    .clk_i(clk), .rst_ni(rst_ni), .cp_en_i(cp_en_i), .cp_wr_i(cp_wr_i),
    .cp_addr_i(cp_addr_i), .cp_commit_i(cp_commit_i), .cp_wdata_i(cp_wdata_i),
    .sec_ctl_i(sec_ctl_i), .cp_rdata_o(cp_rdata_o), .trc_regs_o(trc_regs_o),
    .ctx_id_o(ctx_id_o)
  );

  function automatic bit f_trc(logic [14:0] a);
    return a[3] == 1'b0 && a[14:12] == 3'd1 && a[11:8] == 4'd0 && a[2:0] == 3'd0;
  endfunction

  function automatic bit f_ctx(logic [14:0] a);
    return a[3] == 1'b1 && a[14:12] == 3'd0 && a[11:8] == 4'd13 &&
           a[7:4] == 4'd0 && a[2:0] == 3'd1;
  endfunction

  function automatic logic [14:0] trc_addr(int k);
    return {3'd1, 4'd0, 4'(k), 1'b0, 3'd0};
  endfunction

  localparam logic [14:0] CTX_ADDR = {3'd0, 4'd13, 4'd0, 1'b1, 3'd1};

  function automatic txn_t mk(logic wr, logic [14:0] a, logic cm, logic [31:0] d, logic [1:0] s);
    txn_t t;
    t.v = 1'b1; t.wr = wr; t.cm = cm; t.a = a; t.d = d; t.s = s;
    return t;
  endfunction

  function automatic txn_t idle_t();
    txn_t t;
    t = '0;
    return t;
  endfunction

  task automatic check_all();
    bit bad = 1'b0;
    n_chk++;
    for (int k = 0; k < NREG; k++) begin
      if (!bad && trc_regs_o[k*DW +: DW] !== m_regs[k]) begin
        $display("FAIL %s trace reg %0d actual %h expected %h", cur_req, k,
                 trc_regs_o[k*DW +: DW], m_regs[k]);
        bad = 1'b1;
      end
    end
    if (!bad && ctx_id_o !== m_ctx) begin
      $display("FAIL %s context reg actual %h expected %h", cur_req, ctx_id_o, m_ctx);
      bad = 1'b1;
    end
    if (!bad && cp_rdata_o !== 32'd0) begin
      $display("FAIL R8 read data actual %h expected 00000000", cp_rdata_o);
      bad = 1'b1;
    end
    if (bad) n_fail++;
  endtask

  // one cycle: check, drive new request phase and the commit phase of the txn two steps back
  task automatic step(txn_t t);
    @(negedge clk);
    check_all();
    cp_en_i     = t.v;
    cp_wr_i     = t.v ? t.wr : 1'($urandom);
    cp_addr_i   = t.v ? t.a : 15'($urandom);
    cp_commit_i = sl2.v ? sl2.cm : 1'b0;
    cp_wdata_i  = sl2.v ? sl2.d : $urandom;
    sec_ctl_i   = sl2.v ? sl2.s : 2'($urandom);
    @(posedge clk);
    if (sl2.v && sl2.cm && sl2.wr && sl2.s != 2'b11) begin
      if (f_trc(sl2.a)) m_regs[sl2.a[7:4]] = sl2.d;
      if (f_ctx(sl2.a)) m_ctx = sl2.d;
    end
    sl2 = sl1;
    sl1 = t;
  endtask

  task automatic flush();
    step(idle_t());
    step(idle_t());
    step(idle_t());
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired during %s", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    for (int k = 0; k < NREG; k++) m_regs[k] = '0;
    m_ctx = '0;
    sl1 = '0;
    sl2 = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    cur_req = "R1";
    @(negedge clk);
    check_all();

    // R2: single write, outputs compared every cycle so early/late update mismatches
    cur_req = "R2";
    step(mk(1'b1, trc_addr(3), 1'b1, 32'hA5A5_0003, 2'b00));
    flush();

    // R3: cancelled writes to a real register and the context register
    cur_req = "R3";
    step(mk(1'b1, trc_addr(3), 1'b0, 32'hDEAD_BEEF, 2'b00));
    step(mk(1'b1, CTX_ADDR, 1'b0, 32'hDEAD_BEEF, 2'b00));
    flush();

    // R5: every trace register with distinct data
    cur_req = "R5";
    for (int k = 0; k < NREG; k++)
      step(mk(1'b1, trc_addr(k), 1'b1, 32'h1000_0000 + 32'(k * 7), 2'b00));
    flush();

    // R6: context write
    cur_req = "R6";
    step(mk(1'b1, CTX_ADDR, 1'b1, 32'h0C7C_0001, 2'b00));
    flush();

    // R4: enable in the commit cycle of the previous txn, then every cycle
    cur_req = "R4";
    step(mk(1'b1, trc_addr(5), 1'b1, 32'h4444_0005, 2'b00));
    step(idle_t());
    step(mk(1'b1, trc_addr(6), 1'b1, 32'h4444_0006, 2'b00));
    step(idle_t());
    step(mk(1'b1, trc_addr(5), 1'b0, 32'h4444_9999, 2'b00));
    step(mk(1'b1, trc_addr(7), 1'b1, 32'h4444_0007, 2'b00));
    step(mk(1'b1, CTX_ADDR, 1'b1, 32'h4444_C7C7, 2'b00));
    step(mk(1'b1, trc_addr(7), 1'b1, 32'h4444_0077, 2'b00));
    flush();

    // R7: near-miss addresses
    cur_req = "R7";
    step(mk(1'b1, {3'd1, 4'd0, 4'd2, 1'b0, 3'd1}, 1'b1, 32'h7777_0001, 2'b00));
    step(mk(1'b1, {3'd1, 4'd1, 4'd2, 1'b0, 3'd0}, 1'b1, 32'h7777_0002, 2'b00));
    step(mk(1'b1, {3'd0, 4'd0, 4'd2, 1'b0, 3'd0}, 1'b1, 32'h7777_0003, 2'b00));
    step(mk(1'b1, {3'd1, 4'd0, 4'd2, 1'b1, 3'd0}, 1'b1, 32'h7777_0004, 2'b00));
    step(mk(1'b1, {3'd0, 4'd13, 4'd1, 1'b1, 3'd1}, 1'b1, 32'h7777_0005, 2'b00));
    step(mk(1'b1, {3'd0, 4'd13, 4'd0, 1'b1, 3'd2}, 1'b1, 32'h7777_0006, 2'b00));
    step(mk(1'b1, {3'd0, 4'd13, 4'd0, 1'b0, 3'd1}, 1'b1, 32'h7777_0007, 2'b00));
    flush();

    // R8: reads with commit high leave everything untouched
    cur_req = "R8";
    step(mk(1'b0, trc_addr(2), 1'b1, 32'h8888_0002, 2'b00));
    step(mk(1'b0, CTX_ADDR, 1'b1, 32'h8888_0003, 2'b00));
    flush();

    // R9: security gating sampled in the commit cycle
    cur_req = "R9";
    step(mk(1'b1, trc_addr(9), 1'b1, 32'h9999_0011, 2'b11));
    step(mk(1'b1, CTX_ADDR, 1'b1, 32'h9999_0C11, 2'b11));
    step(mk(1'b1, trc_addr(9), 1'b1, 32'h9999_0010, 2'b10));
    step(mk(1'b1, trc_addr(10), 1'b1, 32'h9999_0001, 2'b01));
    step(mk(1'b1, CTX_ADDR, 1'b1, 32'h9999_0C01, 2'b01));
    flush();

    // constrained random mix
    cur_req = "R2";
    for (int n = 0; n < 3000; n++) begin
      txn_t t;
      int sel;
      sel = int'($urandom_range(0, 9));
      if ($urandom_range(0, 9) < 3) t = idle_t();
      else begin
        logic [14:0] a;
        if (sel < 6)      a = {3'd1, 4'd0, 4'($urandom), 1'b0, ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'd0};
        else if (sel < 8) a = CTX_ADDR;
        else              a = 15'($urandom);
        t = mk($urandom_range(0, 4) != 0, a, $urandom_range(0, 3) != 0, $urandom, 2'($urandom));
      end
      step(t);
    end
    flush();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule